// File: doc/BRIEF.md
# Dual-Layer Bitmap Row Renderer

This block turns one character slot of a scanline into two coloured pixels. Video memory is 64 KiB and holds two 4-bit-per-pixel layers. The background layer sits in the lower 32 KiB and the foreground layer in the upper 32 KiB, at the same offset. For each slot, the CRT controller supplies a memory address, a raster line within the character row and the slot index. The block issues one read to each layer, splits each byte into a left and a right nibble, and merges the layers. In the foreground, a zero nibble is transparent. The result is two 8-bit palette indices, each tagged with its screen coordinates.

Per-line settings are latched when the line starts: the colour bank, screen flip, video enable and the output line number. Once latched, they hold for every slot in that line. Each slot takes four clock cycles. The block ignores a new request while a slot is in flight. The video memory is a synchronous RAM whose read data returns one cycle after the address.

Top module: `layer_row_render`

## Requirements
- R1: Out of reset, `pixValid`, `vramRd` and `slotBusy` are 0, and the line settings read as video disabled.
- R2: A request accepted at clock edge N makes two reads. The first is during the cycle after N, at the background address (0x400 + ((ma << 3) | (ra << 7) | idx)) mod 0x8000. The second is during the following cycle, at the same address with bit 15 set (foreground).
- R3: The low nibble of each fetched byte forms the left pixel, at x = 2·idx. The high nibble forms the right pixel, at x = 2·idx + 1.
- R4: The palette index is {bank[2:0], layer, nibble}. The layer bit is 0 for a background pixel and 1 for a foreground pixel.
- R5: A foreground nibble of 0 shows the background nibble. Any other foreground nibble replaces it.
- R6: With flip latched, the output line is 240 − y. Each pixel x becomes (256 − x) mod 256.
- R7: With video enable latched low, both palette indices are 0x00 (black), whatever the memory holds.
- R8: For a request accepted at edge N, `pixValid` is high for exactly one cycle, from edge N+3 to N+4.
- R9: `slotBusy` is high for the three cycles after acceptance. Requests sampled in those cycles are dropped, and so are their address inputs.
- R10: Bank, flip, enable and line number are taken only on `lineStart`. Changing them between pulses does not alter the pixels produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Latches the per-line settings |
| lineY | input | 9 | Raster line number for the line |
| colorBank | input | 3 | Colour bank for the line |
| flipEn | input | 1 | Screen flip for the line |
| videoEn | input | 1 | Video enable for the line |
| slotReq | input | 1 | Start a character slot |
| crtcMa | input | 12 | CRT controller memory address |
| crtcRa | input | 5 | Raster line within the character row |
| slotIdx | input | 7 | Character index within the row |
| slotBusy | output | 1 | Slot in flight; requests are dropped |
| vramRd | output | 1 | Video memory read enable |
| vramAddr | output | 16 | Video memory byte address |
| vramData | input | 8 | Read data, one cycle after the address |
| pixValid | output | 1 | Pixel pair is valid |
| pixY | output | 9 | Output line number |
| pixXLeft | output | 8 | X of left pixel |
| pixXRight | output | 8 | X of right pixel |
| palLeft | output | 8 | Palette index of left pixel |
| palRight | output | 8 | Palette index of right pixel |

## Verification
The assertions assume that read data returns exactly one cycle after `vramRd`. They also assume that `lineStart` is pulsed only while the block is idle, so line settings never change during a slot. The stimulus uses a RAM model with a single-cycle read latency. It pulses `lineStart` only between slots, and then scrambles the raw line inputs to show that they are latched. The stimulus also holds `slotReq` high with different addresses during busy cycles. Any extra output pair produced by those requests reaches the scoreboard as an unexpected result.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BG, ST_FG, ST_WAIT} lrrState_t;

  typedef struct packed {
    logic latchSlot;
    logic rdBg;
    logic rdFg;
    logic capBg;
    logic emit;
  } lrrStrobe_t;
endpackage

// File: rtl/lrr_ctrl.sv
module lrr_ctrl
  import lrr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotReq,
  output lrrStrobe_t strb,
  output logic       busy
);
  lrrState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: if (slotReq) state <= ST_BG;
        ST_BG:   state <= ST_FG;
        ST_FG:   state <= ST_WAIT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchSlot = (state == ST_IDLE) && slotReq;
    strb.rdBg      = (state == ST_BG);
    strb.rdFg      = (state == ST_FG);
    strb.capBg     = (state == ST_FG);
    strb.emit      = (state == ST_WAIT);
  end

  assign busy = (state != ST_IDLE);

  // R9: once raised, busy spans exactly three cycles
  p_busy_span_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 busy ##1 !busy);
endmodule

// File: rtl/lrr_datapath.sv
module lrr_datapath
  import lrr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MA_W      = 12,
  parameter int RA_W      = 5,
  parameter int IDX_W     = 7,
  parameter int Y_W       = 9,
  parameter int BANK_W    = 3,
  parameter int MA_SH     = 3,
  parameter int RA_SH     = 7,
  parameter int BASE_OFF  = 'h400,
  parameter int FLIP_Y    = 240,
  parameter int FLIP_X    = 256,
  parameter int BLANK_IDX = 0,
  localparam int NIB_W    = 4,
  localparam int X_W      = IDX_W + 1,
  localparam int PAL_W    = BANK_W + 1 + NIB_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  lrrStrobe_t        strb,
  input  logic              lineStart,
  input  logic [Y_W-1:0]    lineY,
  input  logic [BANK_W-1:0] colorBank,
  input  logic              flipEn,
  input  logic              videoEn,
  input  logic [MA_W-1:0]   crtcMa,
  input  logic [RA_W-1:0]   crtcRa,
  input  logic [IDX_W-1:0]  slotIdx,
  output logic              vramRd,
  output logic [ADDR_W-1:0] vramAddr,
  input  logic [2*NIB_W-1:0] vramData,
  output logic              pixValid,
  output logic [Y_W-1:0]    pixY,
  output logic [X_W-1:0]    pixXLeft,
  output logic [X_W-1:0]    pixXRight,
  output logic [PAL_W-1:0]  palLeft,
  output logic [PAL_W-1:0]  palRight
);
  localparam logic [X_W-1:0]   FLIP_X_L = X_W'(FLIP_X);
  localparam logic [Y_W-1:0]   FLIP_Y_L = Y_W'(FLIP_Y);
  localparam logic [PAL_W-1:0] BLANK_L  = PAL_W'(BLANK_IDX);

  logic [BANK_W-1:0] lineBank;
  logic              lineFlip, lineEn;
  logic [Y_W-1:0]    lineYQ;
  logic [ADDR_W-2:0] slotAddr;
  logic [IDX_W-1:0]  slotIdxQ;
  logic [2*NIB_W-1:0] bgByte;
  logic [ADDR_W-1:0] rawSum;

  assign rawSum = ADDR_W'(BASE_OFF) + ((ADDR_W'(crtcMa) << MA_SH) |
                  (ADDR_W'(crtcRa) << RA_SH) | ADDR_W'(slotIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBank <= '0; lineFlip <= 1'b0; lineEn <= 1'b0; lineYQ <= '0;
    end else if (lineStart) begin
      lineBank <= colorBank; lineFlip <= flipEn; lineEn <= videoEn; lineYQ <= lineY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotAddr <= '0; slotIdxQ <= '0; bgByte <= '0;
    end else begin
      if (strb.latchSlot) begin
        slotAddr <= rawSum[ADDR_W-2:0];
        slotIdxQ <= slotIdx;
      end
      if (strb.capBg) bgByte <= vramData;
    end
  end

  assign vramRd   = strb.rdBg | strb.rdFg;
  assign vramAddr = {strb.rdFg, slotAddr};

  logic [1:0][PAL_W-1:0] palNext;
  logic [1:0][X_W-1:0]   xNext;

  for (genvar g = 0; g < 2; g++) begin : g_pix
    logic [NIB_W-1:0] fgNib, bgNib;
    logic [X_W-1:0]   xRaw;
    assign fgNib = vramData[g*NIB_W +: NIB_W];
    assign bgNib = bgByte[g*NIB_W +: NIB_W];
    assign xRaw  = {slotIdxQ, 1'(g)};
    assign xNext[g] = lineFlip ? (FLIP_X_L - xRaw) : xRaw;
    assign palNext[g] = !lineEn ? BLANK_L :
                        (fgNib != '0) ? {lineBank, 1'b1, fgNib} : {lineBank, 1'b0, bgNib};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0; pixY <= '0; pixXLeft <= '0; pixXRight <= '0;
      palLeft <= '0; palRight <= '0;
    end else begin
      pixValid <= strb.emit;
      if (strb.emit) begin
        pixY      <= lineFlip ? (FLIP_Y_L - lineYQ) : lineYQ;
        pixXLeft  <= xNext[0];
        pixXRight <= xNext[1];
        palLeft   <= palNext[0];
        palRight  <= palNext[1];
      end
    end
  end

  // R5: a foreground-tagged index never carries the transparent nibble
  p_fg_opaque_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && palLeft[NIB_W] |-> palLeft[NIB_W-1:0] != '0);
  // R4: both pixels of a pair share one bank
  p_bank_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> palLeft[PAL_W-1 -: BANK_W] == palRight[PAL_W-1 -: BANK_W]);
  // R3/R6: right pixel sits one step from the left, direction set by flip
  p_pair_x_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> pixXRight == (lineFlip ? pixXLeft - 1'b1 : pixXLeft + 1'b1));
endmodule

// File: rtl/layer_row_render.sv
module layer_row_render
  import lrr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  logic [8:0] lineY,
  input  logic [2:0] colorBank,
  input  logic       flipEn,
  input  logic       videoEn,
  input  logic       slotReq,
  input  logic [11:0] crtcMa,
  input  logic [4:0] crtcRa,
  input  logic [6:0] slotIdx,
  output logic       slotBusy,
  output logic       vramRd,
  output logic [15:0] vramAddr,
  input  logic [7:0] vramData,
  output logic       pixValid,
  output logic [8:0] pixY,
  output logic [7:0] pixXLeft,
  output logic [7:0] pixXRight,
  output logic [7:0] palLeft,
  output logic [7:0] palRight
);
  lrrStrobe_t strb;

  lrr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .slotReq(slotReq), .strb(strb), .busy(slotBusy)
  );

  lrr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lineStart(lineStart), .lineY(lineY), .colorBank(colorBank),
    .flipEn(flipEn), .videoEn(videoEn),
    .crtcMa(crtcMa), .crtcRa(crtcRa), .slotIdx(slotIdx),
    .vramRd(vramRd), .vramAddr(vramAddr), .vramData(vramData),
    .pixValid(pixValid), .pixY(pixY), .pixXLeft(pixXLeft), .pixXRight(pixXRight),
    .palLeft(palLeft), .palRight(palRight)
  );

  // R2: a background read is followed at once by the foreground read at the mirrored address
  p_fg_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    vramRd && !vramAddr[15] |=> vramRd && vramAddr == ($past(vramAddr) | 16'h8000));
  // R8: a pixel pair comes after exactly two reads and one idle read cycle
  p_valid_reads_r8: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> !$past(vramRd, 1) && $past(vramRd, 2) && $past(vramRd, 3));
  // R8: valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);
endmodule

// File: tb/test_layer_row_render.sv
module test_layer_row_render;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, lineStart, flipEn, videoEn, slotReq;
  logic [8:0] lineY;
  logic [2:0] colorBank;
  logic [11:0] crtcMa;
  logic [4:0] crtcRa;
  logic [6:0] slotIdx;
  logic       slotBusy, vramRd, pixValid;
  logic [15:0] vramAddr;
  logic [7:0] vramData, pixXLeft, pixXRight, palLeft, palRight;
  logic [8:0] pixY;

  layer_row_render i_layer_row_render (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;

  typedef struct packed {
    logic [8:0] y; logic [7:0] xl; logic [7:0] xr; logic [7:0] pl; logic [7:0] pr;
  } pix_t;
  pix_t expQ[$];

  // bench model of the line settings
  logic [2:0] mBank = 0; logic mFlip = 0, mEn = 0; logic [8:0] mY = 0;

  function automatic logic [7:0] memFn(input logic [15:0] a);
    logic [7:0] h;
    h = (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    if (a[15]) begin
      case (a[1:0])
        2'd0: return 8'h00;
        2'd1: return {h[7:4] | 4'h1, 4'h0};
        2'd2: return {4'h0, h[3:0] | 4'h2};
        default: return h;
      endcase
    end
    return h;
  endfunction

  always_ff @(posedge clk) if (vramRd) vramData <= memFn(vramAddr);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare (R3 R4 R5 R6 R7 R8 R9 R10)
  always @(negedge clk) begin
    if (rstN && pixValid) begin
      pix_t act;
      act = {pixY, pixXLeft, pixXRight, palLeft, palRight};
      if (expQ.size() == 0) check(1'b0, "R9 unexpected pixel pair", act, 0);
      else begin
        pix_t e;
        e = expQ.pop_front();
        check(act == e, "R3/R4/R5/R6/R7/R10 pixel pair", act, e);
      end
    end
  end

  function automatic logic [7:0] palOf(input logic [3:0] fg, input logic [3:0] bg);
    if (!mEn) return 8'h00;
    return (fg != 0) ? {mBank, 1'b1, fg} : {mBank, 1'b0, bg};
  endfunction

  task automatic startLine(input logic [8:0] y, input logic [2:0] b, input logic f, input logic en);
    @(negedge clk);
    lineY = y; colorBank = b; flipEn = f; videoEn = en; lineStart = 1;
    @(negedge clk);
    lineStart = 0;
    mY = y; mBank = b; mFlip = f; mEn = en;
    // R10: scramble raw inputs after the latch
    lineY = ~y; colorBank = ~b; flipEn = ~f; videoEn = ~en;
  endtask

  task automatic doSlot(input logic [11:0] ma, input logic [4:0] ra, input logic [6:0] idx, input bit poke);
    logic [15:0] bgA, fgA; logic [7:0] bgB, fgB, x0, x1; pix_t e;
    bgA = (16'h0400 + ((16'(ma) << 3) | (16'(ra) << 7) | 16'(idx))) & 16'h7FFF;
    fgA = bgA | 16'h8000;
    bgB = memFn(bgA); fgB = memFn(fgA);
    x0 = {idx, 1'b0}; x1 = {idx, 1'b1};
    if (mFlip) begin x0 = 8'd0 - x0; x1 = 8'd0 - x1; end
    e.y  = mFlip ? 9'd240 - mY : mY;
    e.xl = x0; e.xr = x1;
    e.pl = palOf(fgB[3:0], bgB[3:0]);
    e.pr = palOf(fgB[7:4], bgB[7:4]);
    expQ.push_back(e);
    @(negedge clk);
    crtcMa = ma; crtcRa = ra; slotIdx = idx; slotReq = 1;
    @(negedge clk);
    if (poke) begin crtcMa = ~ma; crtcRa = ~ra; slotIdx = ~idx; end
    else slotReq = 0;
    check(vramRd && vramAddr == bgA, "R2 background read", {vramRd, vramAddr}, {1'b1, bgA});
    check(slotBusy, "R9 busy after accept", slotBusy, 1);
    @(negedge clk);
    check(vramRd && vramAddr == fgA, "R2 foreground read", {vramRd, vramAddr}, {1'b1, fgA});
    @(negedge clk);
    check(!vramRd && !pixValid, "R8 no early output", {vramRd, pixValid}, 0);
    @(negedge clk);
    slotReq = 0;
    check(pixValid && !slotBusy, "R8 valid at N+3", {pixValid, slotBusy}, 2'b10);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    rstN = 0; lineStart = 0; lineY = 0; colorBank = 0; flipEn = 0; videoEn = 0;
    slotReq = 0; crtcMa = 0; crtcRa = 0; slotIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!pixValid, "R1 pixValid idle", pixValid, 0);
    check(!vramRd, "R1 vramRd idle", vramRd, 0);
    check(!slotBusy, "R1 slotBusy idle", slotBusy, 0);
    // R1/R7: before any line start video reads as disabled
    doSlot(12'h010, 5'd1, 7'd3, 0);

    startLine(9'd10, 3'd5, 0, 1);
    for (int k = 0; k < 8; k++) doSlot(12'h123, 5'd2, 7'(k), 0);
    doSlot(12'hFFF, 5'd31, 7'd127, 0);   // R2 address wrap
    doSlot(12'h000, 5'd0, 7'd0, 0);

    startLine(9'd17, 3'd2, 1, 1);        // R6 flip
    doSlot(12'h040, 5'd3, 7'd0, 0);
    doSlot(12'h040, 5'd3, 7'd127, 0);
    doSlot(12'h2A5, 5'd9, 7'd64, 0);

    startLine(9'd240, 3'd7, 1, 1);
    doSlot(12'h0F0, 5'd4, 7'd5, 1);      // R9 requests during busy dropped
    doSlot(12'h0F1, 5'd5, 7'd6, 1);

    startLine(9'd100, 3'd1, 0, 0);       // R7 blanking
    doSlot(12'h333, 5'd7, 7'd9, 0);
    doSlot(12'h334, 5'd7, 7'd10, 0);

    startLine(9'd0, 3'd0, 0, 1);
    for (int k = 0; k < 4; k++) doSlot(12'h200, 5'd0, 7'(k + 40), 0);

    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R8/R9 all expected pairs produced", expQ.size(), 0);
    finishRun();
  end
endmodule